// File: doc/BRIEF.md
# GPIO Output Function Multiplexer

This block controls the output side of a bank of general-purpose pads. Each pad either drives a level that software writes, or carries one of a set of internal status signals such as activity LEDs, a transmit-frame indicator, a receive-clear flag or coexistence data and clock lines. A 2-bit drive-mode field per pad decides whether the pad drives at all. The block also returns the pad input levels to software through a two-flop synchronizer.

Software reaches the block over a simple single-cycle bus with word addresses. A write takes effect at the clock edge where `bus_wr` is high. Read data appears on `bus_rdata` one cycle after `bus_rd` and then holds. Two pads can never drive. One is reserved and one is input-only. The two lowest pads are shared with a debug port and act as GPIO only after a release bit is set. Pad pull and strength controls and input-side routing are handled outside this block.

Top module: `gpio_fmux`

## Requirements
- R1: After reset, every register reads 0, and `pad_out` and `pad_oe` are all 0.
- R2: The function-select registers sit at word addresses 0, 1 and 2. Pin p has a 5-bit code at bit (p mod 6)×5 of register p/6. Register 2 stores only the bits that belong to existing pins (bits 9:0 for 14 pins), and its other bits read 0. A write to any register shows on `bus_rdata` one cycle after a read of that address.
- R3: With code 0, `pad_out[p]` equals bit p of the level register at address 4.
- R4: The drive-mode register at address 3 holds the mode of pin p in bits 2p+1:2p. The encodings are: 00 never drive, 11 always drive, 01 drive only while the pin value is 0, 10 drive only while the pin value is 1.
- R5: Pins 8 and 9 never assert `pad_oe` and always show 0 on `pad_out`, whatever is programmed.
- R6: While bit 0 of the control register at address 5 is 0, pins 0 and 1 hold `pad_oe` and `pad_out` at 0. Once the bit is set, they behave like any other pin.
- R7: A code c from 1 to NUM_FUNC (20) routes `func_sig[c-1]` to the pin. Codes above NUM_FUNC give a value of 0.
- R8: Address 6 reads `pad_in` after two synchronizing flops, with bit 8 always read as 0. Writes to address 6 are ignored.
- R9: Addresses 7 and above read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (4) | Word address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid the cycle after `bus_rd` |
| func_sig | input | NUM_FUNC (20) | Internal signals that the pins can select |
| pad_in | input | NUM_PINS (14) | Pad input levels, asynchronous |
| pad_out | output | NUM_PINS (14) | Per-pin output value |
| pad_oe | output | NUM_PINS (14) | Per-pin output enable |

## Verification
The hardest case to reach is the pair of conditional drive modes. In these modes the enable follows the value the pin carries, so a mistake only shows when both the mode and the value polarity are covered. The stimulus programs one pin as drive-when-low and a neighbour as drive-when-high. It then writes level patterns that first disable and then enable both pins, with the debug-shared pins already released so that they do not hide bits. The blocked pins get live codes and set level bits on purpose, so any leakage onto their outputs is visible.

// File: rtl/gpio_fmux_pkg.sv
package gpio_fmux_pkg;
    localparam int SEL_W        = 5;
    localparam int PINS_PER_SEL = 6;
    localparam int RSV_PIN      = 8;
    localparam int IN_ONLY_PIN  = 9;
    localparam int DBG_PINS     = 2;

    // word addresses
    localparam int A_SEL_BASE = 0;
    localparam int A_DRIVE    = 3;
    localparam int A_LEVEL    = 4;
    localparam int A_CTRL     = 5;
    localparam int A_INVAL    = 6;

    typedef enum logic [1:0] {
        DRV_OFF       = 2'b00,
        DRV_LOW_ONLY  = 2'b01,
        DRV_HIGH_ONLY = 2'b10,
        DRV_ON        = 2'b11
    } drive_mode_e;
endpackage

// File: rtl/gpio_fmux_sync.sv
module gpio_fmux_sync #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            d_sync <= '0;
        end else begin
            meta_q <= d_async;
            d_sync <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_fmux_regs.sv
module gpio_fmux_regs
    import gpio_fmux_pkg::*;
#(
    parameter int NUM_PINS = 14,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4,
    parameter int NUM_SEL  = (NUM_PINS + PINS_PER_SEL - 1) / PINS_PER_SEL
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic [NUM_PINS-1:0]        in_sync,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic [NUM_SEL*DATA_W-1:0]  sel_flat,
    output logic [2*NUM_PINS-1:0]      drive_q,
    output logic [NUM_PINS-1:0]        level_q,
    output logic                       dbg_release
);
    localparam logic [NUM_PINS-1:0] IN_MASK = ~(NUM_PINS'(1) << RSV_PIN);

    logic [DATA_W-1:0] sel_q [NUM_SEL];
    logic [DATA_W-1:0] rd_next;

    function automatic logic [DATA_W-1:0] sel_mask(input int idx);
        int n;
        logic [DATA_W-1:0] m;
        n = NUM_PINS - idx * PINS_PER_SEL;
        if (n > PINS_PER_SEL) n = PINS_PER_SEL;
        m = '0;
        for (int b = 0; b < n * SEL_W; b++) m[b] = 1'b1;
        return m;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_SEL; r++) sel_q[r] <= '0;
            drive_q     <= '0;
            level_q     <= '0;
            dbg_release <= 1'b0;
        end else if (bus_wr) begin
            for (int r = 0; r < NUM_SEL; r++)
                if (bus_addr == ADDR_W'(A_SEL_BASE + r))
                    sel_q[r] <= bus_wdata & sel_mask(r);
            if (bus_addr == ADDR_W'(A_DRIVE)) drive_q     <= bus_wdata[2*NUM_PINS-1:0];
            if (bus_addr == ADDR_W'(A_LEVEL)) level_q     <= bus_wdata[NUM_PINS-1:0];
            if (bus_addr == ADDR_W'(A_CTRL))  dbg_release <= bus_wdata[0];
        end
    end

    always_comb begin
        rd_next = '0;
        for (int r = 0; r < NUM_SEL; r++)
            if (bus_addr == ADDR_W'(A_SEL_BASE + r)) rd_next = sel_q[r];
        if (bus_addr == ADDR_W'(A_DRIVE)) rd_next = DATA_W'(drive_q);
        if (bus_addr == ADDR_W'(A_LEVEL)) rd_next = DATA_W'(level_q);
        if (bus_addr == ADDR_W'(A_CTRL))  rd_next = DATA_W'(dbg_release);
        if (bus_addr == ADDR_W'(A_INVAL)) rd_next = DATA_W'(in_sync & IN_MASK);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

    for (genvar r = 0; r < NUM_SEL; r++) begin : g_flat
        assign sel_flat[r*DATA_W +: DATA_W] = sel_q[r];
    end
endmodule

// File: rtl/gpio_fmux_pin.sv
module gpio_fmux_pin
    import gpio_fmux_pkg::*;
#(
    parameter int PIN_IDX  = 0,
    parameter int NUM_FUNC = 20
) (
    input  logic [SEL_W-1:0]    code,
    input  logic [1:0]          mode,
    input  logic                level,
    input  logic [NUM_FUNC-1:0] func_sig,
    input  logic                dbg_release,
    output logic                out,
    output logic                oe
);
    localparam bit NEVER_DRIVE = (PIN_IDX == RSV_PIN) || (PIN_IDX == IN_ONLY_PIN);
    localparam bit DBG_SHARED  = (PIN_IDX < DBG_PINS);

    logic value;
    logic want_oe;
    logic blocked;

    always_comb begin
        value = 1'b0;
        if (code == '0) value = level;
        for (int f = 0; f < NUM_FUNC; f++)
            if (code == SEL_W'(f + 1)) value = func_sig[f];
    end

    always_comb begin
        unique case (drive_mode_e'(mode))
            DRV_OFF:       want_oe = 1'b0;
            DRV_LOW_ONLY:  want_oe = ~value;
            DRV_HIGH_ONLY: want_oe = value;
            DRV_ON:        want_oe = 1'b1;
            default:       want_oe = 1'b0;
        endcase
    end

    assign blocked = NEVER_DRIVE || (DBG_SHARED && !dbg_release);
    assign out     = blocked ? 1'b0 : value;
    assign oe      = blocked ? 1'b0 : want_oe;
endmodule

// File: rtl/gpio_fmux.sv
module gpio_fmux
    import gpio_fmux_pkg::*;
#(
    parameter int NUM_PINS = 14,
    parameter int NUM_FUNC = 20,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_FUNC-1:0] func_sig,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);
    localparam int NUM_SEL = (NUM_PINS + PINS_PER_SEL - 1) / PINS_PER_SEL;

    logic [NUM_PINS-1:0]       in_sync;
    logic [NUM_SEL*DATA_W-1:0] sel_flat;
    logic [2*NUM_PINS-1:0]     drive_q;
    logic [NUM_PINS-1:0]       level_q;
    logic                      dbg_release;

    gpio_fmux_sync #(.W(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pad_in), .d_sync(in_sync)
    );

    gpio_fmux_regs #(
        .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_SEL(NUM_SEL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .in_sync(in_sync),
        .bus_rdata(bus_rdata), .sel_flat(sel_flat), .drive_q(drive_q),
        .level_q(level_q), .dbg_release(dbg_release)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int SEL_LSB = (p / PINS_PER_SEL) * DATA_W + (p % PINS_PER_SEL) * SEL_W;
        gpio_fmux_pin #(.PIN_IDX(p), .NUM_FUNC(NUM_FUNC)) u_pin (
            .code(sel_flat[SEL_LSB +: SEL_W]),
            .mode(drive_q[2*p +: 2]),
            .level(level_q[p]),
            .func_sig(func_sig),
            .dbg_release(dbg_release),
            .out(pad_out[p]),
            .oe(pad_oe[p])
        );
    end
endmodule

// File: rtl/gpio_fmux_chk.sv
module gpio_fmux_chk
    import gpio_fmux_pkg::*;
#(
    parameter int NUM_PINS = 14,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_rd,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [DATA_W-1:0]     bus_rdata,
    input logic [NUM_PINS-1:0]   pad_out,
    input logic [NUM_PINS-1:0]   pad_oe,
    input logic                  dbg_release,
    input logic [2*NUM_PINS-1:0] drive_bits
);
    logic [NUM_PINS-1:0] off_mask;

    always_comb
        for (int i = 0; i < NUM_PINS; i++)
            off_mask[i] = (drive_bits[2*i +: 2] == 2'b00);

    assert_tristate_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & off_mask) == '0);

    assert_blocked_pins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe[RSV_PIN] == 1'b0) && (pad_oe[IN_ONLY_PIN] == 1'b0)
        && (pad_out[RSV_PIN] == 1'b0) && (pad_out[IN_ONLY_PIN] == 1'b0));

    assert_debug_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_release |-> (pad_oe[DBG_PINS-1:0] == '0) && (pad_out[DBG_PINS-1:0] == '0));

    assert_in_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(A_INVAL)) |=> (bus_rdata[RSV_PIN] == 1'b0));

    assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr > ADDR_W'(A_INVAL)) |=> (bus_rdata == '0));
endmodule

bind gpio_fmux gpio_fmux_chk #(
    .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .pad_out(pad_out), .pad_oe(pad_oe),
    .dbg_release(dbg_release), .drive_bits(drive_q)
);

// File: tb/gpio_fmux_bench.sv
module gpio_fmux_bench;
    localparam int NP = 14;
    localparam int NF = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NF-1:0] func_sig = '0;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_fmux u_gpio_fmux (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .func_sig(func_sig), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // scoreboard: kind 0 = pad_out, 1 = pad_oe, 2 = bus_rdata
    typedef struct {
        int          kind;
        logic [31:0] exp;
        logic [31:0] mask;
        string       req;
    } item_t;

    item_t q[$];
    event  chk_ev;

    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.kind)
                    0:       act = 32'(pad_out);
                    1:       act = 32'(pad_oe);
                    default: act = bus_rdata;
                endcase
                compared++;
                if ((act & it.mask) !== (it.exp & it.mask)) begin
                    mismatched++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h mask=%h",
                             it.req, it.kind, act, it.exp, it.mask);
                end
            end
        end
    end

    task automatic expect_item(input int kind, input logic [31:0] exp,
                               input logic [31:0] mask, input string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.mask = mask; it.req = req;
        q.push_back(it);
        ->chk_ev;
        #1;
    endtask

    task automatic expect_pads(input logic [NP-1:0] eo, input logic [NP-1:0] ee,
                               input string req);
        expect_item(0, 32'(eo), 32'h3FFF, req);
        expect_item(1, 32'(ee), 32'h3FFF, req);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_expect(input logic [3:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        expect_item(2, exp, 32'hFFFF_FFFF, req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_pads(14'h0000, 14'h0000, "R1");
        for (int a = 0; a < 7; a++) rd_expect(4'(a), 32'h0, "R1");

        // R2 write/read of select registers, packing of the last register
        wr(4'd1, 32'hFFFF_FFFF);
        rd_expect(4'd1, 32'h3FFF_FFFF, "R2");
        wr(4'd2, 32'hFFFF_FFFF);
        rd_expect(4'd2, 32'h0000_03FF, "R2");
        wr(4'd1, 32'h0);
        wr(4'd2, 32'h0);
        rd_expect(4'd2, 32'h0, "R2");

        // R3 level routing with code 0, all pins always-drive, debug pins held (R6)
        wr(4'd3, 32'h0FFF_FFFF);
        wr(4'd4, 32'h0000_2AAA);
        expect_pads(14'h28A8, 14'h3CFC, "R3");
        expect_pads(14'h28A8, 14'h3CFC, "R6");

        // R6 release of debug-shared pins
        wr(4'd5, 32'h1);
        rd_expect(4'd5, 32'h1, "R2");
        expect_pads(14'h28AA, 14'h3CFF, "R6");

        // R3 second pattern
        wr(4'd4, 32'h0000_1555);
        expect_pads(14'h1455, 14'h3CFF, "R3");

        // R4 conditional modes: pin2 low-only, pin3 high-only, pin4 off
        wr(4'd3, 32'h0FFF_FC9F);
        expect_pads(14'h1455, 14'h3CE3, "R4");
        wr(4'd4, 32'h0000_0008);
        expect_pads(14'h0008, 14'h3CEF, "R4");

        // R5 blocked pins with live code and set level bits
        wr(4'd1, 32'h0000_8000);            // pin9 code 1
        func_sig = 20'h00001;
        wr(4'd4, 32'h0000_0308);
        expect_item(0, 32'h0, 32'h0300, "R5");
        expect_item(1, 32'h0, 32'h0300, "R5");
        wr(4'd1, 32'h0);
        wr(4'd4, 32'h0000_0008);

        // R7 internal signal routing and unimplemented code
        wr(4'd0, (32'd1 << 25) | (32'd20 << 20) | (32'd25 << 15));
        func_sig = 20'h80001;
        #1;
        expect_pads(14'h0030, 14'h3CE7, "R7");
        func_sig = 20'h00000;
        #1;
        expect_item(0, 32'h0, 32'h3FFF, "R7");
        wr(4'd2, 32'h0000_0002);            // pin12 code 2
        func_sig = 20'h80003;
        #1;
        expect_item(0, 32'h1030, 32'h3FFF, "R7");

        // R8 synchronized input readback
        pad_in = 14'h3FFF;
        repeat (3) @(negedge clk);
        rd_expect(4'd6, 32'h0000_3EFF, "R8");
        wr(4'd6, 32'h0);
        rd_expect(4'd6, 32'h0000_3EFF, "R8");
        pad_in = 14'h0100;
        repeat (3) @(negedge clk);
        rd_expect(4'd6, 32'h0, "R8");

        // R9 unmapped address
        wr(4'd9, 32'hDEAD_BEEF);
        rd_expect(4'd9, 32'h0, "R9");
        rd_expect(4'd15, 32'h0, "R9");
        rd_expect(4'd4, 32'h0000_0008, "R9");
        rd_expect(4'd3, 32'h0FFF_FC9F, "R9");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule